// File: doc/BRIEF.md
# INT8 Systolic Matrix-Multiply Engine

This block computes the square product C = A × W of two signed 8-bit matrices. It keeps every result as a signed 32-bit sum. Software first writes three base addresses into a small register file: the activation matrix A, the weight matrix W and the output matrix C. It then writes the matrix size N and sets the start bit. From there the engine runs the job without any further help from the CPU. It reads operands from a single-port SRAM, one word per cycle. It feeds them into a 4×4 output-stationary grid of multiply-accumulate elements, and writes the 32-bit results back to the same SRAM.

The output is built one 4×4 tile at a time, so one job covers a matrix of any size up to the configured maximum. For each tile and each inner index k, the sequencer fetches four activation values (one per row of the tile) and four weight values (one per column). It then injects them together as one beat. A skew stage delays row r of the activations and column c of the weights by r and c cycles, so matching operand pairs meet inside each element. After the last beat of a tile, the engine waits 2·P−1 drain cycles, then writes the sixteen accumulators out. Rows and columns beyond N are padded with zeros and are never written.

All matrices are stored row-major, one element per 32-bit word. Element (i, j) of an N×N matrix sits at base + i·N + j.

Top module: `mm_accel`

## Requirements
- R1: After reset, the status register (address 1) and all base and size registers read 0, and the engine issues no memory request.
- R2: The register map is as follows. Address 0 is control: writing a value with bit 0 set starts a job, and the register reads 0. Address 1 is status: bit 0 is done, bit 1 is busy. Address 2 holds the weight base, address 3 the activation base, address 4 the output base and address 5 the dimension N. Registers 2 to 5 read back the last value written. Read data appears one cycle after the address is presented.
- R3: Each output word at obase + i·N + j equals the sum over k of A[i][k]·W[k][j]. A[i][k] is read from abase + i·N + k and W[k][j] from wbase + k·N + j. Each operand word holds a signed 8-bit value sign-extended to 32 bits.
- R4: When N is not a multiple of 4, the padded tile edges contribute nothing. A job makes exactly N·N memory writes, all inside the output region.
- R5: Busy reads 1 from the accepted START until the last result is written. Done then reads 1 and stays 1 until the next accepted START clears it. Busy and done are never both 1.
- R6: A START written while the engine is busy is ignored. The running job neither restarts nor adds writes.
- R7: The accumulators clear at the start of every output tile. Jobs of several tiles, and jobs run back to back, give results that are independent of earlier tiles.
- R8: A job with N = 0 sets done without any memory access, and status shows done within four cycles of the START write.
- R9: Extreme operands (−128 and 127) accumulate exactly in 32 bits. For example, twelve products of (−128)·(−128) give 196608.
- R10: Base and size registers written while a job runs do not change that job. The engine uses the values captured at START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address, for both write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| mem_req | output | 1 | SRAM access request |
| mem_we | output | 1 | SRAM write enable (only with mem_req) |
| mem_addr | output | 32 | SRAM word address |
| mem_wdata | output | 32 | SRAM write data (32-bit result) |
| mem_rdata | input | 32 | SRAM read data, valid one cycle after the request |

## Verification
A stuck or stale accumulator shows up as a wrong output word in the first tile that follows it. That word is visible in memory as soon as done rises. A skew or lane error mixes mismatched operand pairs, so every element of the affected row or column goes wrong, and the reference product reports it at the first compare. A sequencing fault in the tile or write counters shows as a write count other than N·N, or as a clobbered sentinel word just past the output region. A fault in the handshake shows as a status read that disagrees with the expected busy and done pattern, one cycle after the address is presented.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_STAT  = 3'd1;
  localparam logic [2:0] RA_WBASE = 3'd2;
  localparam logic [2:0] RA_ABASE = 3'd3;
  localparam logic [2:0] RA_OBASE = 3'd4;
  localparam logic [2:0] RA_DIM   = 3'd5;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_INJ,
    S_DRAIN,
    S_WRITE
  } seq_state_t;
endpackage

// File: rtl/mm_regs.sv
module mm_regs
  import mm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              busy_i,
  input  logic              done_pulse_i,
  output logic              start_o,
  output logic [DATA_W-1:0] wbase_o,
  output logic [DATA_W-1:0] abase_o,
  output logic [DATA_W-1:0] obase_o,
  output logic [DATA_W-1:0] dim_o
);
  logic done_q;

  assign start_o = wr_en && (addr == RA_CTRL) && wdata[0] && !busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      wbase_o <= '0;
      abase_o <= '0;
      obase_o <= '0;
      dim_o   <= '0;
      done_q  <= 1'b0;
      rdata   <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          RA_WBASE: wbase_o <= wdata;
          RA_ABASE: abase_o <= wdata;
          RA_OBASE: obase_o <= wdata;
          RA_DIM:   dim_o   <= wdata;
          default:  ;
        endcase
      end
      if (start_o)           done_q <= 1'b0;
      else if (done_pulse_i) done_q <= 1'b1;
      case (addr)
        RA_STAT:  rdata <= DATA_W'({busy_i, done_q});
        RA_WBASE: rdata <= wbase_o;
        RA_ABASE: rdata <= abase_o;
        RA_OBASE: rdata <= obase_o;
        RA_DIM:   rdata <= dim_o;
        default:  rdata <= '0;
      endcase
    end
  end

  // R5: done stays set until a START is accepted
  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start_o) |=> done_q);

  // R5: the sequencer's busy and the done flag never overlap
  assert_busy_done_excl_R5: assert property (@(posedge clk) disable iff (rst)
    busy_i |-> !done_q);
endmodule

// File: rtl/mm_skew.sv
module mm_skew #(
  parameter int LANES = 4,
  parameter int W     = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES-1:0][W-1:0]   in_vec,
  output logic [LANES-1:0][W-1:0]   out_vec
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == 0) begin : g_pass
      assign out_vec[l] = in_vec[l];
    end else begin : g_dly
      logic [W-1:0] sr [l];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < l; s++) sr[s] <= '0;
        end else begin
          sr[0] <= in_vec[l];
          for (int s = 1; s < l; s++) sr[s] <= sr[s-1];
        end
      end
      assign out_vec[l] = sr[l-1];
    end
  end
endmodule

// File: rtl/mm_pe.sv
module mm_pe #(
  parameter int OP_W  = 8,
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic [OP_W-1:0]         a_i,
  input  logic [OP_W-1:0]         w_i,
  output logic [OP_W-1:0]         a_o,
  output logic [OP_W-1:0]         w_o,
  output logic signed [ACC_W-1:0] acc_o
);
  logic signed [2*OP_W-1:0] prod;
  assign prod = $signed(a_i) * $signed(w_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_o   <= '0;
      w_o   <= '0;
      acc_o <= '0;
    end else begin
      a_o   <= a_i;
      w_o   <= w_i;
      acc_o <= clr ? '0 : acc_o + ACC_W'(prod);
    end
  end
endmodule

// File: rtl/mm_grid.sv
module mm_grid #(
  parameter int P     = 4,
  parameter int OP_W  = 8,
  parameter int ACC_W = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr,
  input  logic [P-1:0][OP_W-1:0]      a_edge,
  input  logic [P-1:0][OP_W-1:0]      w_edge,
  output logic [P*P-1:0][ACC_W-1:0]   acc_o
);
  logic [OP_W-1:0] ah [P][P+1];
  logic [OP_W-1:0] wv [P+1][P];

  for (genvar r = 0; r < P; r++) begin : g_row
    assign ah[r][0] = a_edge[r];
    assign wv[0][r] = w_edge[r];
    for (genvar c = 0; c < P; c++) begin : g_col
      mm_pe #(.OP_W(OP_W), .ACC_W(ACC_W)) u_pe (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .a_i   (ah[r][c]),
        .w_i   (wv[r][c]),
        .a_o   (ah[r][c+1]),
        .w_o   (wv[r+1][c]),
        .acc_o (acc_o[r*P+c])
      );
    end
  end

  logic pipe_busy;
  always_comb begin
    pipe_busy = 1'b0;
    for (int i = 0; i < P; i++) begin
      pipe_busy = pipe_busy | (|ah[i][P]) | (|wv[P][i]) | (|a_edge[i]) | (|w_edge[i]);
    end
  end

  // R7: a tile clear never discards operands still moving through the grid
  assert_clear_flushed_R7: assert property (@(posedge clk) disable iff (rst)
    clr |-> !pipe_busy);
endmodule

// File: rtl/mm_seq.sv
module mm_seq
  import mm_pkg::*;
#(
  parameter int P       = 4,
  parameter int OP_W    = 8,
  parameter int ACC_W   = 32,
  parameter int DATA_W  = 32,
  parameter int DIM_W   = 8,
  parameter int MAX_DIM = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_i,
  input  logic [DATA_W-1:0]          wbase_i,
  input  logic [DATA_W-1:0]          abase_i,
  input  logic [DATA_W-1:0]          obase_i,
  input  logic [DATA_W-1:0]          dim_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       clr_o,
  output logic [P-1:0][OP_W-1:0]     a_inj_o,
  output logic [P-1:0][OP_W-1:0]     w_inj_o,
  input  logic [P*P-1:0][ACC_W-1:0]  acc_i,
  output logic                       mem_req_o,
  output logic                       mem_we_o,
  output logic [DATA_W-1:0]          mem_addr_o,
  output logic [DATA_W-1:0]          mem_wdata_o,
  input  logic [DATA_W-1:0]          mem_rdata_i
);
  localparam int P_LG  = $clog2(P);
  localparam int FCW   = P_LG + 2;
  localparam int DCW   = $clog2(2*P);
  localparam int WCW   = 2*P_LG;
  localparam int DRAIN = 2*P - 1;

  seq_state_t state;
  logic [DATA_W-1:0] wbase_l, abase_l, obase_l;
  logic [DIM_W-1:0]  n_l, n_next, ti, tj, k;
  logic [FCW-1:0]    fcnt;
  logic [DCW-1:0]    dcnt;
  logic [WCW-1:0]    widx;
  logic              s1_v, s1_z, s2_v, s2_z;
  logic [P_LG:0]     s1_idx, s2_idx;
  logic [P-1:0][OP_W-1:0] a_stage, w_stage;

  assign n_next = (dim_i > DATA_W'(MAX_DIM)) ? DIM_W'(MAX_DIM) : dim_i[DIM_W-1:0];
  assign busy_o = (state != S_IDLE);

  // tile count
  logic [DIM_W:0] tiles;
  logic           last_tj, last_ti, last_k;
  assign tiles   = ({1'b0, n_l} + (DIM_W+1)'(P-1)) >> P_LG;
  assign last_tj = ({1'b0, tj} == tiles - 1'b1);
  assign last_ti = ({1'b0, ti} == tiles - 1'b1);
  assign last_k  = (k == n_l - 1'b1);

  // operand fetch address
  logic              f_isw, f_inr;
  logic [P_LG-1:0]   f_lane;
  logic [DATA_W-1:0] f_idx, f_addr;
  assign f_isw  = fcnt[P_LG];
  assign f_lane = fcnt[P_LG-1:0];
  assign f_idx  = f_isw ? DATA_W'({tj, f_lane}) : DATA_W'({ti, f_lane});
  assign f_inr  = f_idx < DATA_W'(n_l);
  assign f_addr = f_isw ? wbase_l + DATA_W'(k) * DATA_W'(n_l) + f_idx
                        : abase_l + f_idx * DATA_W'(n_l) + DATA_W'(k);

  // result write address
  logic [P_LG-1:0]   w_r, w_c;
  logic [DATA_W-1:0] w_row, w_col, w_addr;
  logic              w_inr;
  assign w_r    = widx[WCW-1:P_LG];
  assign w_c    = widx[P_LG-1:0];
  assign w_row  = DATA_W'({ti, w_r});
  assign w_col  = DATA_W'({tj, w_c});
  assign w_inr  = (w_row < DATA_W'(n_l)) && (w_col < DATA_W'(n_l));
  assign w_addr = obase_l + w_row * DATA_W'(n_l) + w_col;

  assign a_inj_o = (state == S_INJ) ? a_stage : '0;
  assign w_inj_o = (state == S_INJ) ? w_stage : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      wbase_l     <= '0;
      abase_l     <= '0;
      obase_l     <= '0;
      n_l         <= '0;
      ti          <= '0;
      tj          <= '0;
      k           <= '0;
      fcnt        <= '0;
      dcnt        <= '0;
      widx        <= '0;
      s1_v        <= 1'b0;
      s1_z        <= 1'b0;
      s1_idx      <= '0;
      s2_v        <= 1'b0;
      s2_z        <= 1'b0;
      s2_idx      <= '0;
      a_stage     <= '0;
      w_stage     <= '0;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      clr_o       <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      mem_req_o <= 1'b0;
      mem_we_o  <= 1'b0;
      clr_o     <= 1'b0;
      done_o    <= 1'b0;
      // read return pipeline: request register, then SRAM output register
      s1_v   <= 1'b0;
      s2_v   <= s1_v;
      s2_z   <= s1_z;
      s2_idx <= s1_idx;
      if (s2_v) begin
        if (s2_idx[P_LG]) w_stage[s2_idx[P_LG-1:0]] <= s2_z ? '0 : mem_rdata_i[OP_W-1:0];
        else              a_stage[s2_idx[P_LG-1:0]] <= s2_z ? '0 : mem_rdata_i[OP_W-1:0];
      end
      case (state)
        S_IDLE: begin
          if (start_i) begin
            wbase_l <= wbase_i;
            abase_l <= abase_i;
            obase_l <= obase_i;
            n_l     <= n_next;
            ti      <= '0;
            tj      <= '0;
            k       <= '0;
            fcnt    <= '0;
            if (n_next == '0) begin
              done_o <= 1'b1;
            end else begin
              clr_o <= 1'b1;
              state <= S_FETCH;
            end
          end
        end
        S_FETCH: begin
          if (!fcnt[FCW-1]) begin
            mem_req_o  <= f_inr;
            mem_addr_o <= f_addr;
            s1_v       <= 1'b1;
            s1_z       <= !f_inr;
            s1_idx     <= fcnt[P_LG:0];
            fcnt       <= fcnt + 1'b1;
          end else if (!s1_v && !s2_v) begin
            state <= S_INJ;
          end
        end
        S_INJ: begin
          fcnt <= '0;
          k    <= k + 1'b1;
          if (last_k) begin
            dcnt  <= '0;
            state <= S_DRAIN;
          end else begin
            state <= S_FETCH;
          end
        end
        S_DRAIN: begin
          if (dcnt == DCW'(DRAIN - 1)) begin
            widx  <= '0;
            state <= S_WRITE;
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        S_WRITE: begin
          mem_req_o   <= w_inr;
          mem_we_o    <= w_inr;
          mem_addr_o  <= w_addr;
          mem_wdata_o <= acc_i[widx];
          widx        <= widx + 1'b1;
          if (widx == WCW'(P*P-1)) begin
            k    <= '0;
            fcnt <= '0;
            if (last_tj && last_ti) begin
              done_o <= 1'b1;
              state  <= S_IDLE;
            end else begin
              if (last_tj) begin
                tj <= '0;
                ti <= ti + 1'b1;
              end else begin
                tj <= tj + 1'b1;
              end
              clr_o <= 1'b1;
              state <= S_FETCH;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6: the register file hands over a start only while the engine is idle
  assert_start_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    start_i |-> (state == S_IDLE));

  // R4: writes always come with a request and stay inside the output region
  assert_we_with_req_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> mem_req_o);
  assert_write_window_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> ((mem_addr_o >= obase_l) &&
                  (mem_addr_o < obase_l + DATA_W'(n_l) * DATA_W'(n_l))));

  // R8: no memory traffic while idle
  assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !$past(busy_o)) |-> !mem_req_o);

  // R3: captured operand words are sign-extended bytes
  assert_operand_sext_R3: assert property (@(posedge clk) disable iff (rst)
    (s2_v && !s2_z) |->
      (mem_rdata_i[DATA_W-1:OP_W] == {(DATA_W-OP_W){mem_rdata_i[OP_W-1]}}));
endmodule

// File: rtl/mm_accel.sv
module mm_accel #(
  parameter int P       = 4,
  parameter int OP_W    = 8,
  parameter int ACC_W   = 32,
  parameter int DATA_W  = 32,
  parameter int DIM_W   = 8,
  parameter int MAX_DIM = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic                      start, busy, done_pulse, clr;
  logic [DATA_W-1:0]         wbase, abase, obase, dim;
  logic [P-1:0][OP_W-1:0]    a_inj, w_inj, a_edge, w_edge;
  logic [P*P-1:0][ACC_W-1:0] acc;

  mm_regs #(.DATA_W(DATA_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (reg_wr_en),
    .addr         (reg_addr),
    .wdata        (reg_wdata),
    .rdata        (reg_rdata),
    .busy_i       (busy),
    .done_pulse_i (done_pulse),
    .start_o      (start),
    .wbase_o      (wbase),
    .abase_o      (abase),
    .obase_o      (obase),
    .dim_o        (dim)
  );

  mm_seq #(
    .P(P), .OP_W(OP_W), .ACC_W(ACC_W), .DATA_W(DATA_W),
    .DIM_W(DIM_W), .MAX_DIM(MAX_DIM)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start),
    .wbase_i     (wbase),
    .abase_i     (abase),
    .obase_i     (obase),
    .dim_i       (dim),
    .busy_o      (busy),
    .done_o      (done_pulse),
    .clr_o       (clr),
    .a_inj_o     (a_inj),
    .w_inj_o     (w_inj),
    .acc_i       (acc),
    .mem_req_o   (mem_req),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata)
  );

  mm_skew #(.LANES(P), .W(OP_W)) u_skew_a (
    .clk     (clk),
    .rst     (rst),
    .in_vec  (a_inj),
    .out_vec (a_edge)
  );

  mm_skew #(.LANES(P), .W(OP_W)) u_skew_w (
    .clk     (clk),
    .rst     (rst),
    .in_vec  (w_inj),
    .out_vec (w_edge)
  );

  mm_grid #(.P(P), .OP_W(OP_W), .ACC_W(ACC_W)) u_grid (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .a_edge (a_edge),
    .w_edge (w_edge),
    .acc_o  (acc)
  );
endmodule

// File: tb/mm_accel_bench.sv
module mm_accel_bench;
  localparam int WB = 'h100;
  localparam int AB = 'h200;
  localparam int OB = 'h400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  logic        tb_we = 1'b0;
  logic [10:0] tb_addr = '0;
  logic [31:0] tb_data = '0;
  logic [31:0] mem [0:2047];
  int          wr_cnt = 0;
  int          req_cnt = 0;
  int          total = 0;
  int          bad = 0;
  int          am [0:143];
  int          wm [0:143];

  always #10 clk = ~clk;

  mm_accel u_mm_accel (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (tb_we) mem[tb_addr] <= tb_data;
    else if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr[10:0]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[10:0]];
      end
    end
    if (mem_req) req_cnt <= req_cnt + 1;
  end

  task automatic check_eq(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reg_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic mem_put(int a, int d);
    @(negedge clk);
    tb_we = 1'b1; tb_addr = 11'(a); tb_data = d;
  endtask

  function automatic int elem(int kind, int i, int j, int seed);
    if (kind == 1) return -128;
    if (kind == 2) return ((i + j + seed) % 2 == 0) ? 127 : -128;
    return ((i * 7 + j * 13 + seed * 29) % 256) - 128;
  endfunction

  task automatic load_mats(int n, int kind, int seed);
    for (int i = 0; i < n; i++)
      for (int j = 0; j < n; j++) begin
        am[i*n+j] = elem(kind, i, j, seed);
        wm[i*n+j] = elem(kind, j, i, seed + 3);
        mem_put(AB + i*n + j, am[i*n+j]);
        mem_put(WB + i*n + j, wm[i*n+j]);
      end
    for (int i = 0; i < n*n + 16; i++) mem_put(OB + i, 32'hDEAD_BEEF);
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic start_job(int n);
    reg_wr(3'd2, WB);
    reg_wr(3'd3, AB);
    reg_wr(3'd4, OB);
    reg_wr(3'd5, n);
    reg_wr(3'd0, 1);
  endtask

  task automatic wait_done(string tag);
    logic [31:0] v;
    for (int c = 0; c < 20000; c++) begin
      reg_rd(3'd1, v);
      if (v[0]) return;
    end
    check_eq({tag, " done timeout"}, 0, 1);
  endtask

  task automatic check_result(int n, string tag);
    for (int i = 0; i < n; i++)
      for (int j = 0; j < n; j++) begin
        int s = 0;
        for (int k = 0; k < n; k++) s += am[i*n+k] * wm[k*n+j];
        check_eq(tag, $signed(mem[OB + i*n + j]), s);
      end
    for (int i = n*n; i < n*n + 16; i++)
      check_eq({tag, " sentinel R4"}, mem[OB + i], 32'hDEAD_BEEF);
  endtask

  task automatic run_job(int n, int kind, int seed, string tag);
    int w0;
    load_mats(n, kind, seed);
    w0 = wr_cnt;
    start_job(n);
    wait_done(tag);
    check_result(n, tag);
    check_eq({tag, " write count R4"}, wr_cnt - w0, n*n);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_rd(3'd1, v); check_eq("R1 status", v, 0);
    reg_rd(3'd2, v); check_eq("R1 wbase", v, 0);
    reg_rd(3'd5, v); check_eq("R1 dim", v, 0);
    check_eq("R1 no request", req_cnt, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    reg_wr(3'd2, 32'h1234_5678); reg_rd(3'd2, v); check_eq("R2 wbase", v, 32'h1234_5678);
    reg_wr(3'd3, 32'hCAFE_0001); reg_rd(3'd3, v); check_eq("R2 abase", v, 32'hCAFE_0001);
    reg_wr(3'd4, 32'h0000_0ABC); reg_rd(3'd4, v); check_eq("R2 obase", v, 32'h0000_0ABC);
    reg_wr(3'd5, 32'd9);         reg_rd(3'd5, v); check_eq("R2 dim", v, 9);
    reg_wr(3'd0, 32'h0000_0000); reg_rd(3'd0, v); check_eq("R2 ctrl reads 0", v, 0);
    reg_rd(3'd1, v); check_eq("R2 no start on bit0 clear", v, 0);
  endtask

  task automatic t_basic();
    run_job(4, 0, 1, "R3 single tile");
  endtask

  task automatic t_multi();
    run_job(8, 0, 2, "R7 four tiles");
    run_job(8, 0, 5, "R7 back to back");
  endtask

  task automatic t_ragged();
    run_job(5, 0, 7, "R4 n5");
    run_job(6, 0, 11, "R4 n6");
  endtask

  task automatic t_extreme();
    run_job(12, 1, 0, "R9 all min");
    check_eq("R9 corner value", $signed(mem[OB]), 196608);
    run_job(7, 2, 1, "R9 mixed extremes");
  endtask

  task automatic t_status();
    logic [31:0] v;
    load_mats(4, 0, 4);
    start_job(4);
    reg_rd(3'd1, v); check_eq("R5 busy after start", v, 2);
    wait_done("R5");
    repeat (40) @(negedge clk);
    reg_rd(3'd1, v); check_eq("R5 done sticky", v, 1);
    reg_wr(3'd0, 1);
    reg_rd(3'd1, v); check_eq("R5 done cleared by start", v, 2);
    wait_done("R5 second");
    check_result(4, "R5 result");
  endtask

  task automatic t_busy();
    logic [31:0] v;
    int w0;
    load_mats(8, 0, 9);
    w0 = wr_cnt;
    start_job(8);
    repeat (30) @(negedge clk);
    reg_wr(3'd5, 3);
    reg_wr(3'd4, OB + 'h100);
    reg_wr(3'd0, 1);
    wait_done("R6");
    check_result(8, "R10 config latched");
    check_eq("R6 write count", wr_cnt - w0, 64);
    repeat (100) @(negedge clk);
    check_eq("R6 no restart writes", wr_cnt - w0, 64);
    reg_rd(3'd1, v); check_eq("R6 done still set", v, 1);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    int r0;
    int seen = 0;
    r0 = req_cnt;
    reg_wr(3'd5, 0);
    reg_wr(3'd0, 1);
    for (int c = 0; c < 4; c++) begin
      reg_rd(3'd1, v);
      if (v[0]) seen = 1;
    end
    check_eq("R8 done quickly", seen, 1);
    check_eq("R8 no memory access", req_cnt - r0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_basic();
    t_multi();
    t_ragged();
    t_extreme();
    t_status();
    t_busy();
    t_zero();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule